// File: doc/BRIEF.md
# Dual-Modulus Programmable Feedback Divider

This block divides a clock by a programmable integer N and produces one output pulse per N input cycles, for use in the feedback path of a clock synthesizer. The pulse goes to a phase-frequency detector, which compares it with the divided reference. Inside, a prescaler that divides by 4 or by 5 is steered by a swallow counter A and a main counter M, with N = 4·M + A.

The modulus arrives as a plain 14-bit binary word. The block samples it only when one output period ends, or while it is idle. A new value written in the middle of a period therefore takes effect at the next period. Some values cannot be built with the prescaler: the swallow count must not exceed the main count, and the main count must be at least one. For such a value the block raises an error flag, emits no pulses and keeps sampling the word on every cycle until a legal value appears.

Top module: `dmod_fb_divider`

## Requirements
- R1: While the synchronous active-low reset is asserted, both `div_pulse` and `mod_err` are 0 after the next clock edge.
- R2: For any word N from 12 to 16383 that stays constant, `div_pulse` rises exactly once every N input clock cycles.
- R3: The words 4, 5, 8, 9 and 10 are also legal and give a pulse every N cycles.
- R4: The words 0, 1, 2, 3, 6, 7 and 11 are illegal. When such a word is sampled, `mod_err` is 1 from the next cycle, and `div_pulse` stays 0 for as long as the flag stays 1.
- R5: Each output pulse is exactly one input clock cycle wide.
- R6: The word is sampled only on the clock edge that closes an output period, or on every edge while the block is idle after reset or after an error. A change at any other time has no effect on the period in progress.
- R7: After reset is released, or after an illegal word is replaced by a legal one, the first pulse appears N cycles after the edge that sampled the legal word, and `mod_err` falls on that edge.
- R8: `mod_err` changes only on sampling edges. An illegal word written in the middle of a period does not cut that period short: its closing pulse is still emitted, and the flag rises on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_word | input | 14 | Modulus N in plain binary |
| div_pulse | output | 1 | One-cycle pulse once per N input cycles |
| mod_err | output | 1 | Set while the last sampled modulus was illegal |

## Verification
The bench uses the default word width of 14 bits. This lets it reach the largest modulus, 16383, and go through every value from 0 to 16, which covers each isolated legal low modulus and each illegal one. With the same width, random legal moduli exercise every mix of divide-by-5 and divide-by-4 prescaler cycles. Mid-period rewrites of the word, legal and illegal, show that a period is never disturbed and that the flag changes only on sampling edges.

// File: rtl/dmod_pkg.sv
// Package: shared types and constants for the dual-modulus feedback divider.
// Assumes a 4/5 prescaler; the prescaler phase counter never exceeds 4.
package dmod_pkg;

    // Prescaler division mode selected by the swallow counter.
    typedef enum logic {
        PS_DIV4 = 1'b0,
        PS_DIV5 = 1'b1
    } ps_mode_e;

    // Width of the prescaler phase counter (counts 0..4).
    localparam int unsigned PS_CNT_W = 3;

    // Final phase value for each prescaler mode.
    localparam logic [PS_CNT_W-1:0] PS_LAST_DIV4 = 3'd3;
    localparam logic [PS_CNT_W-1:0] PS_LAST_DIV5 = 3'd4;

    // Swallow counter width: A = N mod 4.
    localparam int unsigned SWALLOW_W = 2;

endpackage

// File: rtl/dmod_mod_decode.sv
// Module: dmod_mod_decode
// Splits the modulus word into a main count M = N >> 2 and a swallow count
// A = N & 3, and decides whether a 4/5 prescaler can build it (M >= 1 and A <= M).
// Assumes MOD_W >= 5 so that the main count is at least 3 bits wide.
module dmod_mod_decode
    import dmod_pkg::*;
#(
    parameter int unsigned MOD_W = 14
) (
    input  logic [MOD_W-1:0]     mod_word,
    output logic [MOD_W-3:0]     main_cnt,
    output logic [SWALLOW_W-1:0] swallow_cnt,
    output logic                 legal
);
    localparam int unsigned MAIN_W = MOD_W - 2;

    logic [MAIN_W-1:0] swallow_ext;

    // Field split and legality rule.
    always_comb begin
        main_cnt    = mod_word[MOD_W-1:SWALLOW_W];
        swallow_cnt = mod_word[SWALLOW_W-1:0];
        swallow_ext = {{(MAIN_W-SWALLOW_W){1'b0}}, swallow_cnt};
        legal       = (main_cnt != '0) && (swallow_ext <= main_cnt);
    end
endmodule

// File: rtl/dmod_prescaler.sv
// Module: dmod_prescaler
// Synchronous model of a 4/5 dual-modulus prescaler. It counts input clocks
// and flags the final cycle of each prescaler period. Mode is taken from the
// swallow controller; restart forces phase zero on a reload edge.
// Assumes the mode is held steady within a prescaler period.
module dmod_prescaler
    import dmod_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     restart,
    input  ps_mode_e mode,
    output logic     wrap
);
    logic [PS_CNT_W-1:0] phase_q;
    logic [PS_CNT_W-1:0] last_phase;

    // Pick the terminal phase for the current mode and detect it.
    always_comb begin
        last_phase = (mode == PS_DIV5) ? PS_LAST_DIV5 : PS_LAST_DIV4;
        wrap       = run && (phase_q == last_phase);
    end

    // Phase counter: advance while running, wrap at the terminal phase.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= wrap ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/dmod_swallow_ctrl.sv
// Module: dmod_swallow_ctrl
// Holds the main and swallow counters. It selects divide-by-5 while swallow
// cycles remain, and marks the end of an output period after the M-th
// prescaler period. It requests a reload at each period end and on every
// cycle while idle. Assumes the decoded fields are valid whenever legal is 1.
module dmod_swallow_ctrl
    import dmod_pkg::*;
#(
    parameter int unsigned MOD_W = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wrap,
    input  logic                 legal,
    input  logic [MOD_W-3:0]     main_in,
    input  logic [SWALLOW_W-1:0] swallow_in,
    output logic                 run,
    output ps_mode_e             mode,
    output logic                 load,
    output logic                 cycle_end
);
    localparam int unsigned MAIN_W = MOD_W - 2;

    logic [MAIN_W-1:0]    main_q;
    logic [SWALLOW_W-1:0] swallow_q;
    logic                 run_q;

    // Decode mode, end of period and the reload request.
    always_comb begin
        run       = run_q;
        mode      = (swallow_q != '0) ? PS_DIV5 : PS_DIV4;
        cycle_end = run_q && wrap && (main_q == '0);
        load      = !run_q || cycle_end;
    end

    // Counter update: reload on request, otherwise count prescaler periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            main_q    <= '0;
            swallow_q <= '0;
        end else if (load) begin
            if (legal) begin
                run_q     <= 1'b1;
                main_q    <= main_in - 1'b1;
                swallow_q <= swallow_in;
            end else begin
                run_q     <= 1'b0;
                main_q    <= '0;
                swallow_q <= '0;
            end
        end else if (wrap) begin
            main_q <= main_q - 1'b1;
            if (swallow_q != '0) begin
                swallow_q <= swallow_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dmod_fb_divider.sv
// Module: dmod_fb_divider (top)
// Programmable feedback divider: one single-cycle pulse per N input clocks,
// N = 4*M + A, built from a 4/5 prescaler with pulse swallowing. The modulus
// is sampled only at period ends, or while idle. An illegal modulus sets
// mod_err and silences the output. Assumes mod_word is synchronous to clk.
module dmod_fb_divider
    import dmod_pkg::*;
#(
    parameter int unsigned MOD_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MOD_W-1:0] mod_word,
    output logic             div_pulse,
    output logic             mod_err
);
    logic [MOD_W-3:0]     main_cnt;
    logic [SWALLOW_W-1:0] swallow_cnt;
    logic                 legal;
    logic                 run;
    ps_mode_e             mode;
    logic                 load;
    logic                 cycle_end;
    logic                 wrap;
    logic                 pulse_q;
    logic                 err_q;

    dmod_mod_decode #(.MOD_W(MOD_W)) u_decode (
        .mod_word    (mod_word),
        .main_cnt    (main_cnt),
        .swallow_cnt (swallow_cnt),
        .legal       (legal)
    );

    dmod_swallow_ctrl #(.MOD_W(MOD_W)) u_swallow (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap       (wrap),
        .legal      (legal),
        .main_in    (main_cnt),
        .swallow_in (swallow_cnt),
        .run        (run),
        .mode       (mode),
        .load       (load),
        .cycle_end  (cycle_end)
    );

    dmod_prescaler u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (load),
        .mode    (mode),
        .wrap    (wrap)
    );

    // Output registers: pulse on period end, error updated on each reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            pulse_q <= cycle_end;
            if (load) begin
                err_q <= !legal;
            end
        end
    end

    assign div_pulse = pulse_q;
    assign mod_err   = err_q;
endmodule

// File: rtl/dmod_fb_divider_checker.sv
// Module: dmod_fb_divider_checker
// Temporal checks on the divider ports, bound into every instance of the top.
// Assumes a clean synchronous reset at the start of simulation.
module dmod_fb_divider_checker #(
    parameter int unsigned MOD_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [MOD_W-1:0] mod_word,
    input logic             div_pulse,
    input logic             mod_err
);
    logic       seen_pulse;
    logic [2:0] gap_q;
    logic       word_ok;

    // Legal set stated as a list of values, independent of the M/A split.
    always_comb begin
        word_ok = (mod_word >= MOD_W'(12)) || (mod_word == MOD_W'(4)) ||
                  (mod_word == MOD_W'(5))  || (mod_word == MOD_W'(8)) ||
                  (mod_word == MOD_W'(9))  || (mod_word == MOD_W'(10));
    end

    // Saturating count of cycles since the previous pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_pulse <= 1'b0;
            gap_q      <= '0;
        end else if (div_pulse) begin
            seen_pulse <= 1'b1;
            gap_q      <= '0;
        end else if (gap_q != 3'd7) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_single_cycle_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    assert_quiet_on_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mod_err |=> !div_pulse);

    assert_min_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_pulse && div_pulse) |-> (gap_q >= 3'd3));

    assert_err_rise_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_err) |-> !$past(word_ok));

    assert_err_fall_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_err) |-> $past(word_ok));
endmodule

bind dmod_fb_divider dmod_fb_divider_checker #(.MOD_W(MOD_W)) u_dmod_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_word  (mod_word),
    .div_pulse (div_pulse),
    .mod_err   (mod_err)
);

// File: tb/dmod_fb_divider_bench.sv
// Bench: behavioural reference model (remaining-cycle count) updated on every
// rising edge and compared with the DUT outputs on every falling edge.
module dmod_fb_divider_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MOD_W      = 14;
    localparam int WATCHDOG   = 190000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [MOD_W-1:0] word = '0;
    logic             div_pulse;
    logic             mod_err;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    checking = 0;
    string cur_req = "R1";

    // Reference model state.
    int rem = 0;
    bit run = 0;
    bit exp_pulse = 0;
    bit exp_err = 0;

    dmod_fb_divider #(.MOD_W(MOD_W)) u_dmod_fb_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .mod_word  (word),
        .div_pulse (div_pulse),
        .mod_err   (mod_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit legal_n(int n);
        return (n >= 12) || (n == 4) || (n == 5) || (n == 8) || (n == 9) || (n == 10);
    endfunction

    // Reference: sample the word when idle or when the period closes.
    always @(posedge clk) begin
        if (!rst_n) begin
            run = 0; rem = 0; exp_pulse = 0; exp_err = 0;
        end else if (!run || rem == 1) begin
            exp_pulse = run;
            if (legal_n(int'(word))) begin
                run = 1; rem = int'(word); exp_err = 0;
            end else begin
                run = 0; exp_err = 1;
            end
        end else begin
            rem = rem - 1;
            exp_pulse = 0;
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            vectors++;
            if (div_pulse !== exp_pulse || mod_err !== exp_err) begin
                fails++;
                $display("FAIL %s t=%0t word=%0d pulse=%b/%b err=%b/%b (actual/expected)",
                         cur_req, $time, word, div_pulse, exp_pulse, mod_err, exp_err);
            end
        end
    end

    // Watchdog: counts as a failure and still reports the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog R2 cycles=%0d expected<=%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic hold(int n, int cyc, string req);
        cur_req = req;
        word = MOD_W'(n);
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        // R1: reset state.
        repeat (2) @(negedge clk);
        checking = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3/R4/R5: sweep every word 0..16.
        for (int n = 0; n <= 16; n++) begin
            string tag;
            if (n == 4) tag = "R5";
            else if (!legal_n(n)) tag = "R4";
            else if (n < 12) tag = "R3";
            else tag = "R2";
            hold(n, 3 * ((n < 4) ? 4 : n) + 7, tag);
        end

        // R2: random legal moduli plus both ends of the range.
        hold(12, 40, "R2");
        for (int k = 0; k < 8; k++) begin
            int n = int'($urandom_range(2000, 12));
            hold(n, 2 * n + 5, "R2");
        end
        hold(16383, 2 * 16383 + 5, "R2");

        // R6: legal rewrite in the middle of a period.
        hold(100, 130, "R6");
        hold(37, 120, "R6");

        // R8: illegal word written mid-period, then R7 recovery.
        hold(50, 70, "R8");
        hold(6, 60, "R8");
        hold(23, 80, "R7");

        // R1/R7: reset mid-run, then restart.
        cur_req = "R1";
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        hold(9, 40, "R7");

        checking = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule